// File: doc/BRIEF.md
# Random allocation tag generator

This block picks a 4-bit memory allocation tag for a pointer-tagging instruction and returns the address with that tag placed in its upper byte field. In generate mode it starts from a tag and a 16-bit seed held in an internal state register. It clocks a 16-bit linear feedback shift register four times to obtain a 4-bit step count. It then walks forward through the tag space, skipping every tag marked in a 16-bit exclusion mask, once per step. On a valid strobe the chosen tag and the advanced seed are written back to the state register, so the next instruction continues the sequence.

In adjust mode the block serves add/subtract-with-tag instructions. The start tag is taken from the address itself and the step count from an instruction field. Only the control-register exclusion mask applies, and the address is offset by a signed byte amount before the new tag is inserted. The result is combinational in the same cycle as the inputs. The state register can also be written directly, which is how the seed is set up.

Top module: `alloc_tag_gen`

## Requirements
- R1: The state reads back as `state_o[3:0]` = current tag, `state_o[23:8]` = current seed, `state_o[7:4]` = 0. It resets to all zero. A load strobe writes the tag and seed inputs, visible the cycle after.
- R2: In generate mode the exclusion mask is `opnd_i[15:0] | ctl_i[15:0]`. Bit k set excludes tag k. `ctl_i[16]` is the random-mode flag.
- R3: One LFSR step computes fb = s[5]^s[3]^s[2]^s[0] and the new seed {fb, s[15:1]}. Generate mode takes four steps, and the fb of step i (i = 0..3) is bit i of the step count.
- R4: Selection first moves from the start tag upward, modulo 16, to the first tag that is not excluded. For each unit of the step count it then advances at least once more, again to the next tag that is not excluded.
- R5: When all 16 mask bits are set, the result tag is 0 in either mode.
- R6: A generate-mode valid strobe writes the result tag and the seed after four steps into the state, visible the following cycle.
- R7: In generate mode, if the random flag is set and the stored seed is zero, the constant 16'h9C5B is used as the seed before stepping. With the flag clear, a zero seed stays zero and the step count is 0.
- R8: In adjust mode the start tag is `src_addr_i[59:56]` and the step count is `tag_ofs_i`. The mask is `ctl_i[15:0]` alone, so `opnd_i` has no effect. The address is `src_addr_i` plus `byte_ofs_i` sign-extended to 64 bits.
- R9: The result tag occupies `res_addr_o[59:56]`. Every other bit equals the source address in generate mode, and equals the offset sum in adjust mode.
- R10: An adjust-mode strobe leaves the state unchanged. A load in the same cycle as a generate strobe takes priority, so the loaded values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_ld_i | input | 1 | Load the state register |
| st_ld_tag_i | input | 4 | Tag value to load |
| st_ld_seed_i | input | 16 | Seed value to load |
| op_valid_i | input | 1 | Instruction valid strobe |
| op_mode_i | input | 1 | 0 = generate, 1 = adjust |
| src_addr_i | input | 64 | Source address |
| opnd_i | input | 16 | Operand exclusion bits (generate mode) |
| ctl_i | input | 17 | Control: [15:0] exclusion, [16] random flag |
| tag_ofs_i | input | 4 | Tag step count (adjust mode) |
| byte_ofs_i | input | 16 | Signed byte offset (adjust mode) |
| res_addr_o | output | 64 | Address with the new tag inserted |
| res_tag_o | output | 4 | Chosen tag |
| state_o | output | 24 | State register read-back |

## Verification
The tag walk is tried with an empty mask, where it isolates the LFSR step count. It is tried with masks split between operand and control bits, which shows the OR forms the mask, and with a full mask, which forces the zero result. Random sparse and dense masks exercise long skip chains across the 15-to-0 wrap. Zero seeds with the random flag on and off separate forced seeding from a stuck LFSR. Adjust-mode cases use an excluded start tag with step count zero, a wrap from tag 15, a negative byte offset and an operand that would exclude every tag. Together these tell the address-derived start apart from the stored one, and show that the operand plays no part in that mode.

// File: rtl/tagx_pkg.sv
package tagx_pkg;
  localparam int TAG_W  = 4;
  localparam int NTAGS  = 1 << TAG_W;
  localparam int SEED_W = 16;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [NTAGS-1:0]  excl_t;
  typedef logic [SEED_W-1:0] seed_t;

  // Feedback taps of the seed register: bits 5, 3, 2 and 0.
  function automatic logic lfsr_fb(seed_t s);
    return s[5] ^ s[3] ^ s[2] ^ s[0];
  endfunction

  function automatic seed_t lfsr_next(seed_t s);
    return {lfsr_fb(s), s[SEED_W-1:1]};
  endfunction

  // First tag at or above t (modulo NTAGS) whose mask bit is clear.
  function automatic tag_t first_free(tag_t t, excl_t m);
    tag_t r;
    tag_t c;
    logic found;
    r = t;
    found = 1'b0;
    for (int k = 0; k < NTAGS; k++) begin
      c = t + tag_t'(k);
      if (!found && !m[c]) begin
        r = c;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tagx_lfsr.sv
module tagx_lfsr
  import tagx_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  seed_t             seed_i,
  output logic [STEPS-1:0]  step_bits_o,
  output seed_t             seed_o
);
  seed_t chain [0:STEPS];

  assign chain[0] = seed_i;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign step_bits_o[i] = lfsr_fb(chain[i]);
    assign chain[i+1]     = lfsr_next(chain[i]);
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/tagx_walk.sv
module tagx_walk
  import tagx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  tag_t              start_i,
  input  excl_t             excl_i,
  input  logic [CNT_W-1:0]  count_i,
  output tag_t              tag_o
);
  localparam int MAXC = (1 << CNT_W) - 1;

  tag_t cur;

  always_comb begin
    cur = first_free(start_i, excl_i);
    for (int n = 1; n <= MAXC; n++) begin
      if (n <= int'(count_i)) cur = first_free(cur + tag_t'(1), excl_i);
    end
    tag_o = (&excl_i) ? '0 : cur;
  end
endmodule

// File: rtl/tagx_insert.sv
module tagx_insert
  import tagx_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TAG_LSB = 56,
  parameter int OFS_W   = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              add_en_i,
  input  tag_t              tag_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] base;

  assign ofs_ext = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign base    = add_en_i ? (addr_i + ofs_ext) : addr_i;

  always_comb begin
    addr_o = base;
    addr_o[TAG_LSB +: TAG_W] = tag_i;
  end
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen
  import tagx_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          TAG_LSB    = 56,
  parameter int          OFS_W      = 16,
  parameter int          STEPS      = 4,
  parameter logic [15:0] FORCE_SEED = 16'h9C5B
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_ld_i,
  input  logic [TAG_W-1:0]             st_ld_tag_i,
  input  logic [SEED_W-1:0]            st_ld_seed_i,
  input  logic                         op_valid_i,
  input  logic                         op_mode_i,
  input  logic [ADDR_W-1:0]            src_addr_i,
  input  logic [NTAGS-1:0]             opnd_i,
  input  logic [NTAGS:0]               ctl_i,
  input  logic [TAG_W-1:0]             tag_ofs_i,
  input  logic [OFS_W-1:0]             byte_ofs_i,
  output logic [ADDR_W-1:0]            res_addr_o,
  output logic [TAG_W-1:0]             res_tag_o,
  output logic [8+SEED_W-1:0]          state_o
);
  localparam int SEED_LSB = 8;
  localparam int CNT_W    = (STEPS > TAG_W) ? STEPS : TAG_W;
  localparam logic [ADDR_W-1:0] TAG_MASK =
    {{(ADDR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

  // Architectural state
  tag_t  st_tag_q;
  seed_t st_seed_q;

  // Named internal events
  logic             is_adj;
  logic             rnd_flag;
  logic             seed_forced;
  logic             gen_wb;
  excl_t            excl;
  seed_t            seed_in;
  seed_t            seed_adv;
  logic [STEPS-1:0] rnd_ofs;
  tag_t             start_tag;
  logic [CNT_W-1:0] step_cnt;

  assign is_adj      = op_mode_i;
  assign rnd_flag    = ctl_i[NTAGS];
  assign excl        = is_adj ? ctl_i[NTAGS-1:0] : (ctl_i[NTAGS-1:0] | opnd_i);
  assign seed_forced = rnd_flag && (st_seed_q == '0);
  assign seed_in     = seed_forced ? FORCE_SEED : st_seed_q;
  assign start_tag   = is_adj ? src_addr_i[TAG_LSB +: TAG_W] : st_tag_q;
  assign step_cnt    = is_adj ? CNT_W'(tag_ofs_i) : CNT_W'(rnd_ofs);
  assign gen_wb      = op_valid_i && !is_adj && !st_ld_i;

  tagx_lfsr #(.STEPS(STEPS)) u_lfsr (
    .seed_i      (seed_in),
    .step_bits_o (rnd_ofs),
    .seed_o      (seed_adv)
  );

  tagx_walk #(.CNT_W(CNT_W)) u_walk (
    .start_i (start_tag),
    .excl_i  (excl),
    .count_i (step_cnt),
    .tag_o   (res_tag_o)
  );

  tagx_insert #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .OFS_W(OFS_W)) u_ins (
    .addr_i   (src_addr_i),
    .ofs_i    (byte_ofs_i),
    .add_en_i (is_adj),
    .tag_i    (res_tag_o),
    .addr_o   (res_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tag_q  <= '0;
      st_seed_q <= '0;
    end else if (st_ld_i) begin
      st_tag_q  <= st_ld_tag_i;
      st_seed_q <= st_ld_seed_i;
    end else if (gen_wb) begin
      st_tag_q  <= res_tag_o;
      st_seed_q <= seed_adv;
    end
  end

  assign state_o = {st_seed_q, {(SEED_LSB-TAG_W){1'b0}}, st_tag_q};

  // R5
  full_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&excl) |-> (res_tag_o == '0));

  // R4
  tag_not_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&excl) |-> !excl[res_tag_o]);

  // R9
  addr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_adj |-> ((res_addr_o & ~TAG_MASK) == (src_addr_i & ~TAG_MASK)));

  // R6
  tag_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wb |=> (st_tag_q == $past(res_tag_o)));

  // R7
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_wb && rnd_flag) |=> (st_seed_q != '0));

  // R10
  adj_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && is_adj && !st_ld_i) |=> $stable(state_o));

  // R1
  state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ld_i |=> (st_tag_q == $past(st_ld_tag_i)) && (st_seed_q == $past(st_ld_seed_i)));
endmodule

// File: tb/alloc_tag_gen_tb.sv
module alloc_tag_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FORCE_VAL = 16'h9C5B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_ld = 1'b0;
  logic [3:0]  st_ld_tag = '0;
  logic [15:0] st_ld_seed = '0;
  logic        op_valid = 1'b0;
  logic        op_mode = 1'b0;
  logic [63:0] src_addr = '0;
  logic [15:0] opnd = '0;
  logic [16:0] ctl = '0;
  logic [3:0]  tag_ofs = '0;
  logic [15:0] byte_ofs = '0;
  logic [63:0] res_addr;
  logic [3:0]  res_tag;
  logic [23:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0]  m_tag = '0;
  logic [15:0] m_seed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alloc_tag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .st_ld_i(st_ld), .st_ld_tag_i(st_ld_tag),
    .st_ld_seed_i(st_ld_seed), .op_valid_i(op_valid), .op_mode_i(op_mode),
    .src_addr_i(src_addr), .opnd_i(opnd), .ctl_i(ctl), .tag_ofs_i(tag_ofs),
    .byte_ofs_i(byte_ofs), .res_addr_o(res_addr), .res_tag_o(res_tag),
    .state_o(state_o)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // {step count, seed after four steps}; taps as a mask 0x002D
  function automatic logic [19:0] ref_lfsr(input logic [15:0] s);
    logic [3:0] o;
    logic b;
    for (int i = 0; i < 4; i++) begin
      b = ^(s & 16'h002D);
      o[i] = b;
      s = (s >> 1) | (16'(b) << 15);
    end
    return {o, s};
  endfunction

  function automatic logic [3:0] ref_pick(input logic [3:0] st, input logic [3:0] cnt,
                                          input logic [15:0] ex);
    int t;
    if (ex == 16'hFFFF) return 4'h0;
    t = st;
    while (ex[t]) t = (t + 1) % 16;
    for (int n = 0; n < cnt; n++) begin
      t = (t + 1) % 16;
      while (ex[t]) t = (t + 1) % 16;
    end
    return t[3:0];
  endfunction

  task automatic do_op(input logic mode, input logic [63:0] src, input logic [15:0] opv,
                       input logic [16:0] cv, input logic [3:0] tofs,
                       input logic [15:0] bofs, input string rq);
    logic [19:0] lr;
    logic [15:0] sd, nsd, ex;
    logic [3:0]  st, cnt, etag;
    logic [63:0] eaddr;
    @(negedge clk);
    op_valid = 1'b1; op_mode = mode; src_addr = src; opnd = opv; ctl = cv;
    tag_ofs = tofs; byte_ofs = bofs;
    if (!mode) begin
      sd    = (cv[16] && m_seed == 16'h0) ? FORCE_VAL : m_seed;
      lr    = ref_lfsr(sd);
      cnt   = lr[19:16];
      nsd   = lr[15:0];
      ex    = opv | cv[15:0];
      st    = m_tag;
      eaddr = src;
    end else begin
      cnt   = tofs;
      nsd   = m_seed;
      ex    = cv[15:0];
      st    = src[59:56];
      eaddr = src + {{48{bofs[15]}}, bofs};
    end
    etag = ref_pick(st, cnt, ex);
    eaddr[59:56] = etag;
    #1;
    chk(rq, 64'(res_tag), 64'(etag));
    chk(mode ? "R8 addr" : "R9 addr", res_addr, eaddr);
    @(negedge clk);
    op_valid = 1'b0;
    if (!mode) begin
      m_tag  = etag;
      m_seed = nsd;
    end
    chk(mode ? "R10 state" : "R6 state", 64'(state_o), 64'({m_seed, 4'h0, m_tag}));
  endtask

  task automatic do_load(input logic [3:0] t, input logic [15:0] s);
    @(negedge clk);
    st_ld = 1'b1; st_ld_tag = t; st_ld_seed = s;
    @(negedge clk);
    st_ld = 1'b0;
    m_tag = t; m_seed = s;
    chk("R1 load", 64'(state_o), 64'({s, 4'h0, t}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL all: watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] ev;
    r = $urandom(32'h00C0FFEE);
    #(CLK_PERIOD * 2 + 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 64'(state_o), 64'h0);

    do_load(4'h5, 16'h1234);
    // R3: empty mask, step count comes from LFSR alone
    do_op(1'b0, 64'h0123_4567_89AB_CDEF, 16'h0, 17'h0, 4'h0, 16'h0, "R3");
    do_op(1'b0, 64'h00FF_0000_0000_1000, 16'h0, 17'h0, 4'h0, 16'h0, "R3");
    // R2: mask split between operand and control
    do_op(1'b0, 64'h0A00_0000_0000_0040, 16'h00F0, 17'h00F0F, 4'h0, 16'h0, "R2");
    // R5: every tag excluded
    do_op(1'b0, 64'h0F00_0000_0000_0000, 16'hFFFF, 17'h0, 4'h0, 16'h0, "R5");
    do_op(1'b1, 64'h0300_0000_0000_0000, 16'h0, 17'h0FFFF, 4'h6, 16'h0, "R5");
    // R7: zero seed, flag clear stays zero; flag set uses forced constant
    do_load(4'h2, 16'h0000);
    do_op(1'b0, 64'h1, 16'h0004, 17'h0, 4'h0, 16'h0, "R7");
    do_op(1'b0, 64'h2, 16'h0, 17'h10000, 4'h0, 16'h0, "R7");
    // R8: excluded start tag with count 0 moves to tag 5
    do_op(1'b1, 64'h0300_0000_0000_0100, 16'h0, 17'h00018, 4'h0, 16'h0010, "R8");
    // R4: wrap from tag 15 with count 2 gives tag 1
    do_op(1'b1, 64'h0F00_0000_0000_0000, 16'h0, 17'h0, 4'h2, 16'h0, "R4");
    // R8: operand bits have no effect in adjust mode; negative offset
    do_op(1'b1, 64'h0700_0000_0001_0000, 16'hFFFF, 17'h0, 4'h3, 16'hFFF0, "R8");
    // R10: load wins over a generate strobe in the same cycle
    @(negedge clk);
    st_ld = 1'b1; st_ld_tag = 4'hC; st_ld_seed = 16'hBEEF;
    op_valid = 1'b1; op_mode = 1'b0; opnd = 16'h0; ctl = 17'h0;
    @(negedge clk);
    st_ld = 1'b0; op_valid = 1'b0;
    m_tag = 4'hC; m_seed = 16'hBEEF;
    chk("R10 load priority", 64'(state_o), 64'({16'hBEEF, 4'h0, 4'hC}));

    for (int i = 0; i < 400; i++) begin
      r  = $urandom;
      ev = 16'($urandom);
      if (r[1:0] == 2'd0) ev = ev & 16'($urandom);
      if (r[3:2] == 2'd0) ev = ev | 16'($urandom);
      if (r[9:4] == 6'd0) do_load(4'($urandom), 16'($urandom));
      do_op(r[12], {$urandom, $urandom}, r[10] ? ev : 16'h0, {r[11], ev ^ 16'($urandom)},
            4'($urandom), 16'($urandom), "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule